// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block gathers up to 128 interrupt request lines and offers one of them to the processor as a vector. Software gives each line a 4-bit priority. A line is a candidate only when its request is active and its priority is strictly greater than the current priority held in the controller. Among the candidates, the highest priority wins. When several candidates share that priority, the one with the smallest index wins. The winner's index, zero-extended to 9 bits, is the vector.

The vector leaves the block as a small stream. `irq_o` is the valid flag and `iack_i` is the ready strobe. `irq_o`, `vec_o` and `vec_prio_o` all come from registers. A handshake happens in a cycle where `irq_o` and `iack_i` are both high, and the processor takes the vector shown in that cycle. An `iack_i` while `irq_o` is low does nothing.

On a handshake the controller pushes the current priority onto a last-in-first-out store and raises the current priority to the acknowledged priority. An end-of-interrupt strobe pops the store and restores the priority that was there before. Software can also overwrite the current priority directly, which lets it hold a ceiling while a shared resource is in use. The lowest-numbered sources can also be raised by software. Such a request stays pending until software clears it.

Top module: `nest_intc`

## Requirements
- R1: After reset, `irq_o` is 0, `cur_prio_o` is 0, `sw_pend_o` is all zero and every priority entry is 0.
- R2: A source is forwarded only if its effective request is high and its priority is strictly greater than `cur_prio_o`. A source whose priority equals the current priority is not forwarded, and a source with priority 0 is never forwarded.
- R3: Among eligible sources the highest priority wins. `vec_o` equals the winner's index zero-extended to `VEC_W` bits, and `vec_prio_o` equals the winner's priority.
- R4: When several eligible sources share the highest priority, the source with the lowest index wins.
- R5: A write through `cpr_we_i`/`cpr_val_i` loads `cur_prio_o` at the next edge.
- R6: A handshake (`iack_i` high while `irq_o` is high) pushes the old `cur_prio_o` onto the store and loads `vec_prio_o` into `cur_prio_o`. `irq_o` is 0 in the cycle after the handshake. An `iack_i` while `irq_o` is 0 changes nothing.
- R7: `eoi_i` with a non-empty store loads `cur_prio_o` from the most recent entry and removes that entry. `eoi_i` with an empty store changes nothing.
- R8: For each source index j below `NUM_SW`, a high bit j of `sw_set_i` sets pending bit j of `sw_pend_o` at the next edge. The bit stays set until bit j of `sw_clr_i` is seen high. If set and clear come together, clear wins. The effective request of source j is `src_req_i[j]` OR that pending bit.
- R9: Hardware requests are level-sensitive: once `src_req_i[k]` falls (and no software pending bit keeps it up), source k is no longer forwarded.
- R10: The store holds `DEPTH` entries. A handshake with a full store still loads the new priority, but the old priority is discarded.
- R11: In one cycle, precedence is handshake, then a pop (`eoi_i` with a non-empty store), then a `cpr_we_i` write. Only the highest-precedence action takes effect.
- R12: `irq_o`, `vec_o` and `vec_prio_o` are registered: a change in the eligible set appears at the edge after it. Any cycle in which `cur_prio_o` is updated forces `irq_o` to 0 at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req_i | input | NUM_SRC | Level-sensitive request lines, one per source |
| prio_we_i | input | 1 | Priority table write strobe |
| prio_idx_i | input | clog2(NUM_SRC) | Source index to write |
| prio_val_i | input | 4 | Priority value to write |
| cpr_we_i | input | 1 | Current-priority write strobe |
| cpr_val_i | input | 4 | Current-priority value to write |
| sw_set_i | input | NUM_SW | Set bits for the software pending flags |
| sw_clr_i | input | NUM_SW | Clear bits for the software pending flags |
| iack_i | input | 1 | Acknowledge, the ready side of the vector stream |
| eoi_i | input | 1 | End-of-interrupt strobe |
| irq_o | output | 1 | Request to the processor, the valid side of the vector stream |
| vec_o | output | VEC_W | Vector of the offered source |
| vec_prio_o | output | 4 | Priority of the offered source |
| cur_prio_o | output | 4 | Current priority mask |
| sw_pend_o | output | NUM_SW | Software pending flags |

## Verification
The bench builds the controller with 16 sources, 4 software-settable sources and a 4-entry priority store. The smaller source count keeps priority tables short to program. The shallow store lets a chain of five nested acknowledges fill it and then overflow it, so the discard on a full store and the unwinding that follows can be observed at `cur_prio_o`. The default widths are used, so the 9-bit vector zero-extension and the full 16-level priority range are still exercised.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int PRIO_W = 4;
  typedef logic [PRIO_W-1:0] prio_t;
  // Action applied to the current-priority register in one cycle
  typedef enum logic [1:0] {
    ACT_NONE,
    ACT_PUSH,
    ACT_POP,
    ACT_LOAD
  } lvl_act_e;
endpackage

// File: rtl/pic_src_regs.sv
module pic_src_regs
  import pic_pkg::*;
#(
  parameter int NUM_SRC = 128,
  parameter int NUM_SW  = 8,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_SRC-1:0]             hw_req_i,
  input  logic                           prio_we_i,
  input  logic [IDX_W-1:0]               prio_idx_i,
  input  prio_t                          prio_val_i,
  input  logic [NUM_SW-1:0]              sw_set_i,
  input  logic [NUM_SW-1:0]              sw_clr_i,
  output logic [NUM_SRC-1:0]             eff_req_o,
  output logic [NUM_SRC-1:0][PRIO_W-1:0] prio_tab_o,
  output logic [NUM_SW-1:0]              sw_pend_o
);

  logic [NUM_SW-1:0] pend_q;

  // Priority table, one register per source
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_tab
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        prio_tab_o[i] <= '0;
      end else if (prio_we_i && (prio_idx_i == IDX_W'(i))) begin
        prio_tab_o[i] <= prio_val_i;
      end
    end
  end

  // Software pending flags: clear has precedence over set
  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q | sw_set_i) & ~sw_clr_i;
  end

  assign sw_pend_o = pend_q;

  // Merge software flags into the low-numbered sources
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_merge
    if (i < NUM_SW) begin : g_sw
      assign eff_req_o[i] = hw_req_i[i] | pend_q[i];
    end else begin : g_hw
      assign eff_req_o[i] = hw_req_i[i];
    end
  end

  // R8
  sw_pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & $past(pend_q & ~sw_clr_i)) == $past(pend_q & ~sw_clr_i)));

endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter
  import pic_pkg::*;
#(
  parameter int NUM_SRC = 128,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]             req_i,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_tab_i,
  input  prio_t                          ceil_i,
  output logic                           found_o,
  output logic [IDX_W-1:0]               idx_o,
  output prio_t                          prio_o
);

  // Scan from the top index down; ">=" lets a lower index take over on a tie
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    prio_o  = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req_i[i] && (prio_tab_i[i] > ceil_i) &&
          (!found_o || (prio_tab_i[i] >= prio_o))) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
        prio_o  = prio_tab_i[i];
      end
    end
  end

endmodule

// File: rtl/pic_prio_stack.sv
module pic_prio_stack
  import pic_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int DW   = $clog2(DEPTH + 1)
) (
  input  logic     clk,
  input  logic     rst_n,
  input  lvl_act_e act_i,
  input  prio_t    load_i,
  output prio_t    cur_o,
  output logic     empty_o
);

  prio_t          mem [DEPTH];
  logic [DW-1:0]  depth_q;
  logic [AW-1:0]  wr_idx;
  logic [AW-1:0]  rd_idx;
  logic [DW-1:0]  depth_dec;

  assign depth_dec = depth_q - DW'(1);
  assign wr_idx    = depth_q[AW-1:0];
  assign rd_idx    = depth_dec[AW-1:0];
  assign empty_o   = (depth_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      depth_q <= '0;
      cur_o   <= '0;
    end else begin
      case (act_i)
        ACT_PUSH: begin
          if (depth_q < DW'(DEPTH)) begin
            mem[wr_idx] <= cur_o;
            depth_q     <= depth_q + DW'(1);
          end
          cur_o <= load_i;
        end
        ACT_POP: begin
          if (!empty_o) begin
            cur_o   <= mem[rd_idx];
            depth_q <= depth_dec;
          end
        end
        ACT_LOAD: cur_o <= load_i;
        default:  ;
      endcase
    end
  end

  // R10
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    depth_q <= DW'(DEPTH));

  // R7
  pop_shrinks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_i == ACT_POP) && !empty_o |=> depth_q == $past(depth_q) - DW'(1));

endmodule

// File: rtl/nest_intc.sv
module nest_intc
  import pic_pkg::*;
#(
  parameter int NUM_SRC = 128,
  parameter int NUM_SW  = 8,
  parameter int DEPTH   = 16,
  parameter int VEC_W   = 9
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_SRC-1:0]         src_req_i,
  input  logic                       prio_we_i,
  input  logic [$clog2(NUM_SRC)-1:0] prio_idx_i,
  input  logic [3:0]                 prio_val_i,
  input  logic                       cpr_we_i,
  input  logic [3:0]                 cpr_val_i,
  input  logic [NUM_SW-1:0]          sw_set_i,
  input  logic [NUM_SW-1:0]          sw_clr_i,
  input  logic                       iack_i,
  input  logic                       eoi_i,
  output logic                       irq_o,
  output logic [VEC_W-1:0]           vec_o,
  output logic [3:0]                 vec_prio_o,
  output logic [3:0]                 cur_prio_o,
  output logic [NUM_SW-1:0]          sw_pend_o
);

  localparam int IDX_W = $clog2(NUM_SRC);

  logic [NUM_SRC-1:0]             eff_req;
  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_tab;
  logic                           win_found;
  logic [IDX_W-1:0]               win_idx;
  prio_t                          win_prio;
  prio_t                          cur_prio;
  logic                           stk_empty;
  lvl_act_e                       act;
  prio_t                          load_val;
  logic                           irq_q;
  logic [IDX_W-1:0]               idx_q;
  prio_t                          vprio_q;
  logic                           handshake;

  pic_src_regs #(.NUM_SRC(NUM_SRC), .NUM_SW(NUM_SW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .hw_req_i   (src_req_i),
    .prio_we_i  (prio_we_i),
    .prio_idx_i (prio_idx_i),
    .prio_val_i (prio_val_i),
    .sw_set_i   (sw_set_i),
    .sw_clr_i   (sw_clr_i),
    .eff_req_o  (eff_req),
    .prio_tab_o (prio_tab),
    .sw_pend_o  (sw_pend_o)
  );

  pic_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
    .req_i      (eff_req),
    .prio_tab_i (prio_tab),
    .ceil_i     (cur_prio),
    .found_o    (win_found),
    .idx_o      (win_idx),
    .prio_o     (win_prio)
  );

  assign handshake = iack_i && irq_q;

  // One action per cycle: acknowledge, then pop, then direct write
  always_comb begin
    act      = ACT_NONE;
    load_val = vprio_q;
    if (handshake) begin
      act = ACT_PUSH;
    end else if (eoi_i && !stk_empty) begin
      act = ACT_POP;
    end else if (cpr_we_i) begin
      act      = ACT_LOAD;
      load_val = cpr_val_i;
    end
  end

  pic_prio_stack #(.DEPTH(DEPTH)) u_stack (
    .clk     (clk),
    .rst_n   (rst_n),
    .act_i   (act),
    .load_i  (load_val),
    .cur_o   (cur_prio),
    .empty_o (stk_empty)
  );

  // Output register; withdrawn whenever the mask moves this edge
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q   <= 1'b0;
      idx_q   <= '0;
      vprio_q <= '0;
    end else begin
      irq_q   <= win_found && (act == ACT_NONE);
      idx_q   <= win_idx;
      vprio_q <= win_prio;
    end
  end

  assign irq_o      = irq_q;
  assign vec_o      = VEC_W'(idx_q);
  assign vec_prio_o = vprio_q;
  assign cur_prio_o = cur_prio;

  // R2
  mask_respected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> vec_prio_o > cur_prio_o);

  // R6
  ack_drops_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iack_i && irq_o |=> !irq_o && (cur_prio_o == $past(vec_prio_o)));

  // R12
  mask_move_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cur_prio_o != $past(cur_prio_o) |-> !irq_o);

endmodule

// File: tb/nest_intc_bench.sv
module nest_intc_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NS  = 16;
  localparam int NSW = 4;
  localparam int DEP = 4;
  localparam int VW  = 9;
  localparam int IW  = $clog2(NS);

  logic           clk = 1'b0;
  logic           rst_n;
  logic [NS-1:0]  src_req;
  logic           prio_we;
  logic [IW-1:0]  prio_idx;
  logic [3:0]     prio_val;
  logic           cpr_we;
  logic [3:0]     cpr_val;
  logic [NSW-1:0] sw_set;
  logic [NSW-1:0] sw_clr;
  logic           iack;
  logic           eoi;
  logic           irq;
  logic [VW-1:0]  vec;
  logic [3:0]     vec_prio;
  logic [3:0]     cur_prio;
  logic [NSW-1:0] sw_pend;

  int checks = 0;
  int fails  = 0;
  bit timed_out = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  nest_intc #(.NUM_SRC(NS), .NUM_SW(NSW), .DEPTH(DEP), .VEC_W(VW)) u_nest_intc (
    .clk(clk), .rst_n(rst_n), .src_req_i(src_req),
    .prio_we_i(prio_we), .prio_idx_i(prio_idx), .prio_val_i(prio_val),
    .cpr_we_i(cpr_we), .cpr_val_i(cpr_val),
    .sw_set_i(sw_set), .sw_clr_i(sw_clr),
    .iack_i(iack), .eoi_i(eoi),
    .irq_o(irq), .vec_o(vec), .vec_prio_o(vec_prio),
    .cur_prio_o(cur_prio), .sw_pend_o(sw_pend)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_prio(input int idx, input int val);
    prio_we  = 1'b1;
    prio_idx = IW'(idx);
    prio_val = 4'(val);
    step();
    prio_we  = 1'b0;
  endtask

  task automatic pulse_ack();
    iack = 1'b1;
    step();
    iack = 1'b0;
  endtask

  task automatic pulse_eoi();
    eoi = 1'b1;
    step();
    eoi = 1'b0;
  endtask

  task automatic write_cpr(input int val);
    cpr_we  = 1'b1;
    cpr_val = 4'(val);
    step();
    cpr_we  = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 irq", irq, 0);
    check("R1 cur_prio", cur_prio, 0);
    check("R1 sw_pend", sw_pend, 0);
    src_req[5] = 1'b1;
    step(); step();
    check("R1 R2 zero priority not forwarded", irq, 0);
  endtask

  task automatic t_select();
    set_prio(5, 3);
    check("R12 registered one edge later", irq, 0);
    step();
    check("R12 irq", irq, 1);
    check("R3 vec single", vec, 5);
    check("R3 vec_prio", vec_prio, 3);
    set_prio(9, 7);
    src_req[9] = 1'b1;
    step();
    check("R3 highest wins", vec, 9);
    set_prio(2, 7);
    src_req[2] = 1'b1;
    step();
    check("R4 tie lowest index", vec, 2);
    src_req[2] = 1'b0;
    step();
    check("R9 level drop", vec, 9);
  endtask

  task automatic t_mask();
    write_cpr(7);
    check("R5 cur_prio loaded", cur_prio, 7);
    check("R12 irq forced low", irq, 0);
    step();
    check("R2 equal priority blocked", irq, 0);
    write_cpr(6);
    step();
    check("R2 above mask forwarded", vec, 9);
    write_cpr(0);
    step();
  endtask

  task automatic t_ack();
    // handshake and eoi together: handshake wins (R11)
    eoi = 1'b1;
    pulse_ack();
    eoi = 1'b0;
    check("R6 R11 cur raised", cur_prio, 7);
    check("R6 irq low after ack", irq, 0);
    step();
    check("R2 lower pending held", irq, 0);
    set_prio(12, 12);
    src_req[12] = 1'b1;
    step(); step();
    check("R3 new winner", vec, 12);
    pulse_ack();
    check("R6 nested raise", cur_prio, 12);
    pulse_eoi();
    check("R7 pop one", cur_prio, 7);
    pulse_eoi();
    check("R7 pop two", cur_prio, 0);
    src_req = '0;
    pulse_eoi();
    check("R7 empty eoi ignored", cur_prio, 0);
    step();
    check("R9 all dropped", irq, 0);
    pulse_ack();
    check("R6 ack without irq", cur_prio, 0);
  endtask

  task automatic t_soft();
    set_prio(1, 4);
    sw_set[1] = 1'b1;
    step();
    sw_set[1] = 1'b0;
    check("R8 pending set", sw_pend, 2);
    step();
    check("R8 sw source offered", vec, 1);
    check("R8 sw irq", irq, 1);
    step(); step();
    check("R8 pending held", sw_pend, 2);
    sw_set[2] = 1'b1;
    sw_clr[2] = 1'b1;
    step();
    sw_set[2] = 1'b0;
    sw_clr[2] = 1'b0;
    check("R8 clear wins", sw_pend, 2);
    sw_clr[1] = 1'b1;
    step();
    sw_clr[1] = 1'b0;
    check("R8 cleared", sw_pend, 0);
    step();
    check("R8 no request after clear", irq, 0);
  endtask

  task automatic nest_one(input int idx, input int pr);
    src_req[idx] = 1'b1;
    step(); step();
    check("R3 chain vec", vec, idx);
    pulse_ack();
    check("R6 chain cur", cur_prio, pr);
    src_req[idx] = 1'b0;
  endtask

  task automatic t_full();
    for (int k = 0; k < 5; k++) set_prio(10 + k, 2 + 2 * k);
    for (int k = 0; k < 5; k++) nest_one(10 + k, 2 + 2 * k);
    pulse_eoi();
    check("R10 overflow discarded", cur_prio, 6);
    eoi = 1'b1;
    cpr_we = 1'b1;
    cpr_val = 4'd15;
    step();
    eoi = 1'b0;
    cpr_we = 1'b0;
    check("R11 pop over write", cur_prio, 4);
    pulse_eoi();
    pulse_eoi();
    check("R10 unwind to base", cur_prio, 0);
  endtask

  task automatic run_all();
    t_reset();
    t_select();
    t_mask();
    t_ack();
    t_soft();
    t_full();
  endtask

  initial begin
    rst_n = 1'b0;
    src_req = '0; prio_we = 1'b0; prio_idx = '0; prio_val = '0;
    cpr_we = 1'b0; cpr_val = '0; sw_set = '0; sw_clr = '0;
    iack = 1'b0; eoi = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    fork
      run_all();
      begin
        repeat (20000) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule